// File: doc/BRIEF.md
# Cross-Domain Station Address Shadow

This block stores one 48-bit station address and its eight filter-control bits. A host writes them through a 32-bit port that has byte enables. The block then delivers a consistent copy of all of them into a separate receive clock domain. The host sees two words:

- The low word (select = 0) holds address bits 31:0.
- The high word (select = 1) holds address bits 47:32 and the control bits: an enable, a source/destination select and six per-byte compare masks.

Receive-side filtering logic reads the copy and never sees a half-updated value.

Writes to the host registers take effect at once on readback. The receive-side copy changes only when the host writes one particular byte lane of the low word. That write takes a snapshot of the whole register pair into a holding register and flips a toggle. The toggle crosses into the receive domain through a two-flop synchronizer. An edge detector there loads every field of the snapshot in a single receive-clock cycle. A strap input picks which lane of the low word arms the transfer.

Top module: `addr_shadow`

## Requirements
- R1: After host reset, reading the low word returns 0xFFFFFFFF and reading the high word returns 0x0000FFFF.
- R2: After receive reset, the receive copy shows address 0xFFFFFFFFFFFF, with enable, select and all six mask bits at 0 and `rxLoad` at 0.
- R3: High-word bits 23:16 always read as zero, whatever value is written to them.
- R4: A write changes only the byte lanes whose `hostByteEn` bit is set. The high word is laid out as bit 31 enable, bit 30 source select, bits 29:24 masks 5..0, and bits 15:0 address 47:32.
- R5: With `bigEndian` = 0, a low-word write with `hostByteEn[3]` set launches a transfer. A low-word write that leaves lane 3 disabled does not launch one.
- R6: With `bigEndian` = 1, a low-word write with `hostByteEn[0]` set launches a transfer. A low-word write that leaves lane 0 disabled does not launch one.
- R7: High-word writes and non-arming low-word writes leave the receive copy unchanged until the next arming write.
- R8: Each transfer delivers every address and control bit at once. The values are those held by the host registers just after the arming write, including the bytes that write itself stored.
- R9: `rxLoad` is high for exactly one receive cycle, and it is high in the same cycle that the receive copy takes its new value. The copy never changes in any other cycle.
- R10: Arming writes spaced at least four receive-clock cycles apart each produce their own transfer, delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host register clock |
| hostRstN | input | 1 | Host domain reset, active low |
| hostWrEn | input | 1 | Write strobe, one cycle per write |
| hostSel | input | 1 | Word select: 0 low word, 1 high word |
| hostByteEn | input | 4 | Per-lane write enables |
| hostWrData | input | 32 | Write data |
| hostRdData | output | 32 | Read data for the selected word |
| bigEndian | input | 1 | Strap: 0 arms on lane 3, 1 arms on lane 0 |
| rxClk | input | 1 | Receive domain clock |
| rxRstN | input | 1 | Receive domain reset, active low |
| rxAddr | output | 48 | Receive copy of the address |
| rxEnable | output | 1 | Receive copy of the enable bit |
| rxSrcSel | output | 1 | Receive copy of the source/destination select |
| rxByteMask | output | 6 | Receive copy of the per-byte masks |
| rxLoad | output | 1 | One-cycle pulse when the copy updates |

## Verification
The bench writes the high word alone and writes low-word lanes that do not arm a transfer. A design that armed on any low-word write, or that copied live registers, would move the receive copy early. The bench flips the strap and confirms that the arming lane moves with it. A design with the lane hard-wired would miss one transfer and invent another. Every receive cycle is compared against a queue of expected snapshots. A design that let fields cross separately, or that sampled registers after a later high-word write, would show a mixed value or a change with no load pulse. Two closely spaced arming writes expose a design that drops or merges transfers.

// File: rtl/addr_shadow_pkg.sv
package addr_shadow_pkg;
  localparam int WORD_W       = 32;
  localparam int LANE_W       = 8;
  localparam int LANES        = WORD_W / LANE_W;
  localparam int ADDR_W       = 48;
  localparam int HI_ADDR_W    = ADDR_W - WORD_W;
  localparam int HI_ADDR_LN   = HI_ADDR_W / LANE_W;
  localparam int MASK_W       = 6;
  localparam int RSVD_W       = WORD_W - LANE_W - HI_ADDR_W;
  localparam int CTRL_LANE    = LANES - 1;
  localparam int LE_TRIG_LANE = LANES - 1;
  localparam int BE_TRIG_LANE = 0;

  typedef struct packed {
    logic              enable;
    logic              srcSel;
    logic [MASK_W-1:0] byteMask;
    logic [ADDR_W-1:0] addr;
  } shadow_t;

  localparam shadow_t SHADOW_RST = '{enable: 1'b0, srcSel: 1'b0,
                                     byteMask: '0, addr: '1};

  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic trigger;
  } strobe_t;
endpackage

// File: rtl/addr_shadow_ctrl.sv
module addr_shadow_ctrl
  import addr_shadow_pkg::*;
(
  input  logic             hostClk,
  input  logic             hostRstN,
  input  logic             hostWrEn,
  input  logic             hostSel,
  input  logic [LANES-1:0] hostByteEn,
  input  logic             bigEndian,
  output strobe_t          strb,
  output logic             toggleQ
);
  logic trigLaneHit;

  assign trigLaneHit  = bigEndian ? hostByteEn[BE_TRIG_LANE] : hostByteEn[LE_TRIG_LANE];
  assign strb.wrLow   = hostWrEn && !hostSel;
  assign strb.wrHigh  = hostWrEn && hostSel;
  assign strb.trigger = strb.wrLow && trigLaneHit;

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) toggleQ <= 1'b0;
    else if (strb.trigger) toggleQ <= ~toggleQ;
  end

  // R5
  le_arm_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (hostWrEn && !hostSel && hostByteEn[LE_TRIG_LANE] && !bigEndian) |=> (toggleQ != $past(toggleQ)));

  // R6
  be_arm_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (hostWrEn && !hostSel && hostByteEn[BE_TRIG_LANE] && bigEndian) |=> (toggleQ != $past(toggleQ)));

  // R7
  high_no_arm_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (hostWrEn && hostSel) |=> $stable(toggleQ));
endmodule

// File: rtl/addr_shadow_regs.sv
module addr_shadow_regs
  import addr_shadow_pkg::*;
(
  input  logic              hostClk,
  input  logic              hostRstN,
  input  strobe_t           strb,
  input  logic              hostSel,
  input  logic [LANES-1:0]  hostByteEn,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output shadow_t           holdQ
);
  logic [WORD_W-1:0]    lowQ, lowNext;
  logic [HI_ADDR_W-1:0] hiAddrQ, hiAddrNext;
  logic [LANE_W-1:0]    ctrlQ, ctrlNext;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lowLane
      assign lowNext[gi*LANE_W +: LANE_W] = (strb.wrLow && hostByteEn[gi])
          ? hostWrData[gi*LANE_W +: LANE_W] : lowQ[gi*LANE_W +: LANE_W];
    end
    for (gi = 0; gi < HI_ADDR_LN; gi++) begin : g_hiLane
      assign hiAddrNext[gi*LANE_W +: LANE_W] = (strb.wrHigh && hostByteEn[gi])
          ? hostWrData[gi*LANE_W +: LANE_W] : hiAddrQ[gi*LANE_W +: LANE_W];
    end
  endgenerate

  assign ctrlNext = (strb.wrHigh && hostByteEn[CTRL_LANE])
      ? hostWrData[CTRL_LANE*LANE_W +: LANE_W] : ctrlQ;

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      lowQ    <= '1;
      hiAddrQ <= '1;
      ctrlQ   <= '0;
      holdQ   <= SHADOW_RST;
    end else begin
      lowQ    <= lowNext;
      hiAddrQ <= hiAddrNext;
      ctrlQ   <= ctrlNext;
      if (strb.trigger) begin
        holdQ.enable   <= ctrlNext[LANE_W-1];
        holdQ.srcSel   <= ctrlNext[LANE_W-2];
        holdQ.byteMask <= ctrlNext[MASK_W-1:0];
        holdQ.addr     <= {hiAddrNext, lowNext};
      end
    end
  end

  assign hostRdData = hostSel ? {ctrlQ, {RSVD_W{1'b0}}, hiAddrQ} : lowQ;

  // R4
  lane_keep_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    (strb.wrLow && !hostByteEn[0]) |=> $stable(lowQ[LANE_W-1:0]));

  // R7
  hold_steady_chk: assert property (@(posedge hostClk) disable iff (!hostRstN)
    !strb.trigger |=> $stable(holdQ));
endmodule

// File: rtl/addr_shadow_cdc.sv
module addr_shadow_cdc
  import addr_shadow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    rxClk,
  input  logic    rxRstN,
  input  logic    toggleIn,
  input  shadow_t holdIn,
  output shadow_t shadowQ,
  output logic    loadQ
);
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgeSeen;

  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN) syncQ <= '0;
    else         syncQ <= {syncQ[SYNC_STAGES-1:0], toggleIn};
  end

  assign edgeSeen = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN) begin
      shadowQ <= SHADOW_RST;
      loadQ   <= 1'b0;
    end else begin
      loadQ <= edgeSeen;
      if (edgeSeen) shadowQ <= holdIn;
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge rxClk) disable iff (!rxRstN)
    loadQ |=> !loadQ);

  // R9
  change_with_load_chk: assert property (@(posedge rxClk) disable iff (!rxRstN)
    !$stable(shadowQ) |-> loadQ);
endmodule

// File: rtl/addr_shadow.sv
module addr_shadow
  import addr_shadow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              hostWrEn,
  input  logic              hostSel,
  input  logic [LANES-1:0]  hostByteEn,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              bigEndian,
  input  logic              rxClk,
  input  logic              rxRstN,
  output logic [ADDR_W-1:0] rxAddr,
  output logic              rxEnable,
  output logic              rxSrcSel,
  output logic [MASK_W-1:0] rxByteMask,
  output logic              rxLoad
);
  strobe_t strb;
  logic    toggle;
  shadow_t hold;
  shadow_t shadow;

  addr_shadow_ctrl u_ctrl (
    .hostClk(hostClk), .hostRstN(hostRstN), .hostWrEn(hostWrEn),
    .hostSel(hostSel), .hostByteEn(hostByteEn), .bigEndian(bigEndian),
    .strb(strb), .toggleQ(toggle)
  );

  addr_shadow_regs u_regs (
    .hostClk(hostClk), .hostRstN(hostRstN), .strb(strb), .hostSel(hostSel),
    .hostByteEn(hostByteEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .holdQ(hold)
  );

  addr_shadow_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .rxClk(rxClk), .rxRstN(rxRstN), .toggleIn(toggle), .holdIn(hold),
    .shadowQ(shadow), .loadQ(rxLoad)
  );

  assign rxAddr     = shadow.addr;
  assign rxEnable   = shadow.enable;
  assign rxSrcSel   = shadow.srcSel;
  assign rxByteMask = shadow.byteMask;
endmodule

// File: tb/addr_shadow_tb.sv
module addr_shadow_tb;
  import addr_shadow_pkg::*;

  logic              hostClk = 1'b0;
  logic              rxClk   = 1'b0;
  logic              hostRstN = 1'b0;
  logic              rxRstN   = 1'b0;
  logic              hostWrEn = 1'b0;
  logic              hostSel  = 1'b0;
  logic [LANES-1:0]  hostByteEn = '0;
  logic [WORD_W-1:0] hostWrData = '0;
  logic [WORD_W-1:0] hostRdData;
  logic              bigEndian = 1'b0;
  logic [ADDR_W-1:0] rxAddr;
  logic              rxEnable, rxSrcSel, rxLoad;
  logic [MASK_W-1:0] rxByteMask;

  int checks = 0;
  int errors = 0;
  int loads  = 0;
  bit monOn  = 1'b0;

  shadow_t expQ[$];
  shadow_t prevOut  = SHADOW_RST;
  bit      prevLoad = 1'b0;
  shadow_t curOut;
  shadow_t popped;

  logic [WORD_W-1:0]    mLow    = '1;
  logic [HI_ADDR_W-1:0] mHiAddr = '1;
  logic [LANE_W-1:0]    mCtrl   = '0;

  always #10 hostClk = ~hostClk;
  always #7  rxClk   = ~rxClk;

  addr_shadow u_dut (
    .hostClk(hostClk), .hostRstN(hostRstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostByteEn(hostByteEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .bigEndian(bigEndian), .rxClk(rxClk), .rxRstN(rxRstN), .rxAddr(rxAddr),
    .rxEnable(rxEnable), .rxSrcSel(rxSrcSel), .rxByteMask(rxByteMask), .rxLoad(rxLoad)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic shadow_t modelSnap();
    shadow_t s;
    s.enable   = mCtrl[7];
    s.srcSel   = mCtrl[6];
    s.byteMask = mCtrl[5:0];
    s.addr     = {mHiAddr, mLow};
    return s;
  endfunction

  // Driver: one write, model update, expected item pushed on an arming write
  task automatic hostWrite(input logic sel, input logic [LANES-1:0] be, input logic [WORD_W-1:0] d);
    bit arm;
    @(negedge hostClk);
    hostWrEn = 1'b1; hostSel = sel; hostByteEn = be; hostWrData = d;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) begin
        if (!sel) mLow[i*8 +: 8] = d[i*8 +: 8];
        else if (i < HI_ADDR_LN) mHiAddr[i*8 +: 8] = d[i*8 +: 8];
        else if (i == CTRL_LANE) mCtrl = d[i*8 +: 8];
      end
    end
    arm = !sel && (bigEndian ? be[0] : be[3]);
    if (arm) expQ.push_back(modelSnap());
    @(negedge hostClk);
    hostWrEn = 1'b0; hostByteEn = '0;
  endtask

  task automatic hostRead(input logic sel, output logic [WORD_W-1:0] d);
    @(negedge hostClk);
    hostSel = sel;
    #1 d = hostRdData;
  endtask

  task automatic waitDrain(input string tag);
    int n = 0;
    while (expQ.size() != 0 && n < 60) begin
      @(negedge hostClk);
      n++;
    end
    repeat (4) @(negedge hostClk);
    chk(tag, 64'(expQ.size()), 64'd0);
  endtask

  function automatic logic [63:0] rxView();
    shadow_t s;
    s = '{enable: rxEnable, srcSel: rxSrcSel, byteMask: rxByteMask, addr: rxAddr};
    return 64'(s);
  endfunction

  // Monitor / scoreboard
  always @(negedge rxClk) begin
    if (monOn) begin
      curOut = '{enable: rxEnable, srcSel: rxSrcSel, byteMask: rxByteMask, addr: rxAddr};
      checks++;
      if (rxLoad) begin
        loads++;
        if (prevLoad) begin
          errors++;
          $display("FAIL R9 load pulse wider than one cycle actual=1 expected=0");
        end
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R7 unexpected transfer actual=%h expected=%h", curOut, prevOut);
        end else begin
          popped = expQ.pop_front();
          if (curOut !== popped) begin
            errors++;
            $display("FAIL R8 transferred copy actual=%h expected=%h", curOut, popped);
          end
        end
      end else if (curOut !== prevOut) begin
        errors++;
        $display("FAIL R9 copy changed without load actual=%h expected=%h", curOut, prevOut);
      end
      prevOut  = curOut;
      prevLoad = rxLoad;
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] rd;
    int loadsBefore;
    repeat (5) @(negedge hostClk);
    hostRstN = 1'b1;
    rxRstN   = 1'b1;
    @(negedge rxClk);
    monOn = 1'b1;

    // R1 / R2 reset state
    hostRead(1'b0, rd); chk("R1 low reset", 64'(rd), 64'hFFFF_FFFF);
    hostRead(1'b1, rd); chk("R1 high reset", 64'(rd), 64'h0000_FFFF);
    chk("R2 rx reset", rxView(), 64'(SHADOW_RST));
    chk("R2 load idle", 64'(rxLoad), 64'd0);

    // R3 / R4 high word full write, reserved lane ignored
    hostWrite(1'b1, 4'b1111, 32'hC5AB_1234);
    hostRead(1'b1, rd); chk("R3 reserved reads zero", 64'(rd), 64'hC500_1234);
    repeat (15) @(negedge hostClk);
    chk("R7 high write no transfer", rxView(), 64'(SHADOW_RST));

    // R4 / R5 partial low write without arming lane
    hostWrite(1'b0, 4'b0101, 32'h1122_3344);
    hostRead(1'b0, rd); chk("R4 lane enables", 64'(rd), 64'hFF22_FF44);
    repeat (15) @(negedge hostClk);
    chk("R5 non-arming lane no transfer", rxView(), 64'(SHADOW_RST));

    // R5 / R8 arming write in little-endian mode
    hostWrite(1'b0, 4'b1000, 32'hAB00_0000);
    waitDrain("R5 arming write delivered");
    chk("R8 copy after arm", rxView(), {8'h0, 1'b1, 1'b1, 6'h05, 48'h1234_AB22_FF44});

    // R7 high change waits for next arm
    hostWrite(1'b1, 4'b1011, 32'h3F00_BEEF);
    repeat (15) @(negedge hostClk);
    chk("R7 copy held", rxView(), {8'h0, 1'b1, 1'b1, 6'h05, 48'h1234_AB22_FF44});
    hostWrite(1'b0, 4'b1111, 32'h0102_0304);
    waitDrain("R7 pending change delivered");
    chk("R8 full copy", rxView(), {8'h0, 1'b0, 1'b0, 6'h3F, 48'hBEEF_0102_0304});

    // R6 big-endian strap
    @(negedge hostClk); bigEndian = 1'b1;
    hostWrite(1'b0, 4'b1000, 32'h5500_0000);
    repeat (15) @(negedge hostClk);
    chk("R6 lane 3 ignored", rxView(), {8'h0, 1'b0, 1'b0, 6'h3F, 48'hBEEF_0102_0304});
    hostWrite(1'b0, 4'b0001, 32'h0000_0077);
    waitDrain("R6 lane 0 arms");
    chk("R6 copy", rxView(), {8'h0, 1'b0, 1'b0, 6'h3F, 48'hBEEF_5502_0377});

    // R10 two arming writes four host cycles apart
    loadsBefore = loads;
    hostWrite(1'b0, 4'b0001, 32'h0000_00A1);
    repeat (2) @(negedge hostClk);
    hostWrite(1'b0, 4'b0011, 32'h0000_B2C3);
    waitDrain("R10 both delivered");
    chk("R10 load count", 64'(loads - loadsBefore), 64'd2);
    chk("R10 final copy", rxView(), {8'h0, 1'b0, 1'b0, 6'h3F, 48'hBEEF_5502_B2C3});
    chk("R9 load low after", 64'(rxLoad), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule